// File: doc/BRIEF.md
# Regulator Power-Good and Open-Phase Supervisor

This block watches the output of a multiphase buck regulator and drives two flags. The power-good flag is high only when two things hold. The digitized feedback voltage must lie inside a window around the nominal target code. Every active phase must also have delivered current recently. The crowbar flag is a separate overvoltage detector with hysteresis. It trips above the upper window bound and holds until the feedback falls to about half of nominal.

The phase sequencer reports per-phase current through end-of-cycle strobes. Each strobe carries a phase tag and a bit that says whether current was detected during that phase's on-time. Each phase keeps a small saturating miss counter. A phase that misses three of its own cycles in a row signals an open power path. This can happen while the voltage still looks good, because the remaining phases keep it up. Either two or three phases are monitored, chosen by a mode input.

Top module: `pgood_supervisor`

## Requirements
- R1: Thresholds derive from the nominal code N as LO = ceil(0.8·N), HI = floor(1.2·N), REL = floor(0.5·N). The power-good flag is registered. One clock after an edge at which LO ≤ fb_code ≤ HI and no open-phase fault is present, it is high.
- R2: If fb_code is below LO or above HI at an edge, the power-good flag is low after that edge, whatever the state of the phases.
- R3: Each phase has a miss count of 0 to 3. A strobe (cyc_end=1) tagged with that phase index (0, 1 or 2) updates the count: it clears to 0 when cyc_cur=1, and otherwise it increments, saturating at 3. Tag value 3 matches no phase.
- R4: An open-phase fault exists while any active phase's count is 3. It forces the power-good flag low at the next edge. The flag returns high once that phase reports current again with the voltage in the window.
- R5: With the crowbar flag low, fb_code > HI at an edge sets it after that edge.
- R6: Once set, the crowbar flag stays set until fb_code < REL at an edge. It clears after that edge.
- R7: With full_phase=1 phases 0 to 2 are active, and with full_phase=0 only phases 0 and 1 are. An inactive phase's count is held at 0, so its strobes never cause a fault, even after it becomes active again.
- R8: While rst_n is low, both flags and all counts are 0. The power-good flag stays low until the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fb_code | input | VW | Digitized feedback voltage |
| vid_code | input | VW | Nominal target code N |
| full_phase | input | 1 | 1: three phases monitored, 0: two |
| cyc_end | input | 1 | End-of-cycle strobe for the tagged phase |
| cyc_phase | input | PW | Phase index of the strobe |
| cyc_cur | input | 1 | Current was detected in that cycle |
| pgood | output | 1 | Power-good flag |
| crowbar | output | 1 | Overvoltage crowbar flag |

## Verification
The hardest state to reach from the ports is an open-phase fault while the voltage sits inside the window. Random strobes rarely give one phase three consecutive misses while the feedback also stays within bounds. Directed sequences hold fb_code at nominal and starve a single phase, checking before and after the third miss. They also check recovery and the case where an inactive third phase is starved and then activated. Random runs mix feedback values set exactly on and one step beyond each threshold.

// File: rtl/pgood_supervisor.sv
module pgood_supervisor #(
  parameter int VW  = 10,
  parameter int NPH = 3,
  localparam int PW = (NPH > 1) ? $clog2(NPH) : 1,
  localparam int XW = VW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] fb_code,
  input  logic [VW-1:0] vid_code,
  input  logic          full_phase,
  input  logic          cyc_end,
  input  logic [PW-1:0] cyc_phase,
  input  logic          cyc_cur,
  output logic          pgood,
  output logic          crowbar
);

  logic [XW-1:0] nom_x, fb_x, lo_thr, hi_thr, rel_thr;
  logic          in_win;
  logic [NPH-1:0] act, dead;
  logic [1:0]     miss [NPH];

  assign nom_x   = XW'(vid_code);
  assign fb_x    = XW'(fb_code);
  assign lo_thr  = (nom_x * XW'(4) + XW'(4)) / XW'(5);
  assign hi_thr  = (nom_x * XW'(6)) / XW'(5);
  assign rel_thr = nom_x >> 1;
  assign in_win  = (fb_x >= lo_thr) && (fb_x <= hi_thr);

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    if (g < NPH - 1) begin : g_fixed
      assign act[g] = 1'b1;
    end else begin : g_opt
      assign act[g] = full_phase;
    end
    assign dead[g] = act[g] && (miss[g] == 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        miss[g] <= 2'd0;
      else if (!act[g])
        miss[g] <= 2'd0;
      else if (cyc_end && cyc_phase == PW'(g)) begin
        if (cyc_cur)
          miss[g] <= 2'd0;
        else if (miss[g] != 2'd3)
          miss[g] <= miss[g] + 2'd1;
      end
    end

    assert_miss_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (miss[g] != $past(miss[g])) |-> (miss[g] == 2'd0 || miss[g] == $past(miss[g]) + 2'd1));

    assert_idle_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !act[g] |=> (miss[g] == 2'd0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgood   <= 1'b0;
      crowbar <= 1'b0;
    end else begin
      pgood   <= in_win && (dead == '0);
      crowbar <= crowbar ? !(fb_x < rel_thr) : (fb_x > hi_thr);
    end
  end

  assert_window_dom_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> ($past(fb_x) >= $past(lo_thr) && $past(fb_x) <= $past(hi_thr)));

  assert_open_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> ($past(dead) == '0));

  assert_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crowbar) |-> ($past(fb_x) > $past(hi_thr)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crowbar) |-> ($past(fb_x) < $past(rel_thr)));

endmodule

// File: tb/sim_pgood_supervisor.sv
module sim_pgood_supervisor;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] fb_code = '0, vid_code = '0;
  logic       full_phase = 1'b1, cyc_end = 1'b0, cyc_cur = 1'b0;
  logic [1:0] cyc_phase = '0;
  logic       pgood, crowbar;

  int errors = 0, checks = 0;
  int mcnt [3];
  bit mcb = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgood_supervisor u0 (.clk(clk), .rst_n(rst_n), .fb_code(fb_code), .vid_code(vid_code),
    .full_phase(full_phase), .cyc_end(cyc_end), .cyc_phase(cyc_phase), .cyc_cur(cyc_cur),
    .pgood(pgood), .crowbar(crowbar));

  function automatic int f_lo(int n); return (4*n + 4) / 5; endfunction
  function automatic int f_hi(int n); return (6*n) / 5; endfunction
  function automatic int f_rel(int n); return n / 2; endfunction

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    int n, f, nact;
    bit win, fault, exp_pg, exp_cb;
    n = vid_code; f = fb_code;
    nact = full_phase ? 3 : 2;
    win = (f >= f_lo(n)) && (f <= f_hi(n));
    fault = 1'b0;
    for (int i = 0; i < nact; i++) if (mcnt[i] == 3) fault = 1'b1;
    exp_pg = win && !fault;
    exp_cb = mcb ? !(f < f_rel(n)) : (f > f_hi(n));
    for (int i = 0; i < 3; i++) begin
      if (i >= nact) mcnt[i] = 0;
      else if (cyc_end && cyc_phase == 2'(i)) mcnt[i] = cyc_cur ? 0 : ((mcnt[i] < 3) ? mcnt[i] + 1 : 3);
    end
    @(posedge clk); #2;
    chk(pgood, exp_pg, tag, "pgood");
    chk(crowbar, exp_cb, mcb ? "R6" : "R5", "crowbar");
    mcb = exp_cb;
  endtask

  task automatic tick(input int ph, input bit cur, input string tag);
    cyc_end = 1'b1; cyc_phase = 2'(ph); cyc_cur = cur;
    step(tag);
    cyc_end = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 3; i++) mcnt[i] = 0;
    vid_code = 10'd400; fb_code = 10'd400;
    repeat (3) @(posedge clk);
    #2;
    chk(pgood, 1'b0, "R8", "pgood in reset");
    chk(crowbar, 1'b0, "R8", "crowbar in reset");
    rst_n = 1'b1;
    #1;
    chk(pgood, 1'b0, "R8", "pgood before first edge");
    step("R8");

    // window boundaries with N=101: LO=81, HI=121
    vid_code = 10'd101;
    fb_code = 10'd81;  step("R1");
    fb_code = 10'd80;  step("R2");
    fb_code = 10'd121; step("R1");
    fb_code = 10'd122; step("R2");
    fb_code = 10'd50;  step("R6");
    fb_code = 10'd49;  step("R6");
    fb_code = 10'd101; step("R1");

    // open phase on phase 1, voltage nominal
    vid_code = 10'd400; fb_code = 10'd400; full_phase = 1'b1;
    step("R1");
    tick(1, 1'b0, "R3");
    tick(1, 1'b0, "R3");
    tick(0, 1'b1, "R3");
    tick(1, 1'b0, "R3");
    step("R4");
    step("R4");
    tick(1, 1'b1, "R4");
    step("R4");
    tick(3, 1'b0, "R3");

    // inactive third phase
    full_phase = 1'b0; step("R7");
    tick(2, 1'b0, "R7");
    tick(2, 1'b0, "R7");
    tick(2, 1'b0, "R7");
    step("R7");
    full_phase = 1'b1; step("R7");
    step("R7");

    // crowbar hysteresis, N=400: HI=480, REL=200
    fb_code = 10'd480; step("R5");
    fb_code = 10'd481; step("R5");
    fb_code = 10'd300; step("R6");
    fb_code = 10'd200; step("R6");
    fb_code = 10'd199; step("R6");
    fb_code = 10'd400; step("R6");

    for (int k = 0; k < 4000; k++) begin
      int n, sel;
      if ($urandom_range(49, 0) == 0) vid_code = 10'($urandom_range(800, 40));
      if ($urandom_range(99, 0) == 0) full_phase = ~full_phase;
      n = vid_code;
      sel = $urandom_range(11, 0);
      case (sel)
        0: fb_code = 10'(f_lo(n));
        1: fb_code = 10'(f_lo(n) - 1);
        2: fb_code = 10'(f_hi(n));
        3: fb_code = 10'(f_hi(n) + 1);
        4: fb_code = 10'(f_rel(n));
        5: fb_code = 10'(f_rel(n) - 1);
        6: fb_code = 10'($urandom_range(1023, 0));
        default: fb_code = 10'(n);
      endcase
      cyc_end = $urandom_range(1, 0) == 1;
      cyc_phase = 2'($urandom_range(3, 0));
      cyc_cur = $urandom_range(9, 0) > 3;
      step("R1");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule